// File: doc/BRIEF.md
# Flash Command Register Interface

This block is the device-side command front end of a byte-wide flash memory. It watches active-low chip-enable, output-enable and write-enable strobes, a 17-bit address and an 8-bit write-data bus, and decodes the one- and two-write command sequences that move the memory between its read, identifier, erase, program and verify modes. The strobes are sampled on the block clock and must already be synchronous to it. Edges of write-enable are found by comparing each sample with the one before.

The block drives a memory back-end. It issues single-cycle start strobes for program and erase, holds the latched program address and data, and steers the array address so that verify reads land on the location named by the command that preceded them. Read data on the bus comes from one of three places: the array, the two identifier bytes, or the verify path. A programming-voltage-good input blocks every command that would change the array. A separate identifier-force input, which stands for a high voltage on an address pin, turns every read into an identifier read.

Top module: `flashcmd_if`

## Requirements
- R1: After reset the mode output is 0 (read array), both start strobes are low, and a read returns the array byte at the live address.
- R2: A write is taken only when chip-enable is low. The address is latched at the falling edge of write-enable and the data at its rising edge, so an address change between the two edges is not seen. A write-enable pulse while chip-enable is high leaves the mode unchanged.
- R3: Command bytes 00H and FFH select read-array mode (mode 0), and two FFH writes in a row from any mode leave the block in mode 0.
- R4: Command bytes 90H and 80H select identifier mode (mode 1). A read then returns 89H when address bit 0 is 0, and the DEV_CODE parameter (default B4H) when address bit 0 is 1.
- R5: Byte 20H selects erase-armed mode (mode 2). A second write of 20H then raises erase_start for exactly one clock. Any other second byte raises no strobe. In both cases the block returns to mode 0.
- R6: Byte 40H selects program-armed mode (mode 4). The next write loads prog_addr with its address and prog_data with its data, and raises prog_start for exactly one clock. The block then returns to mode 0.
- R7: Byte A0H selects erase-verify mode (mode 3). Reads then return the array byte at the address latched with the A0H write, whatever the live address is.
- R8: Byte C0H selects program-verify mode (mode 5). Reads then return the array byte at prog_addr, and arr_addr equals prog_addr.
- R9: While vpp_ok is low, the bytes 20H, A0H, 40H and C0H leave the mode unchanged. The second write of an armed erase or program raises no strobe, leaves prog_addr unchanged, and returns the block to mode 0.
- R10: While id_force is high, reads return the identifier bytes selected by address bit 0 as in R4, in any mode.
- R11: Any command byte other than 00H, FFH, 90H, 80H, 20H, A0H, 40H or C0H returns the block to mode 0.
- R12: dq_oe is high only while chip-enable and output-enable are low and write-enable is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | 17 | Bus address |
| din | input | 8 | Write data / command byte |
| vpp_ok | input | 1 | Programming voltage present; low blocks modifying commands |
| id_force | input | 1 | Forces identifier reads when high |
| arr_rdata | input | 8 | Array read data for arr_addr |
| dq_out | output | 8 | Read data toward the bus |
| dq_oe | output | 1 | Bus output drive enable |
| mode | output | 3 | Current mode (0 read, 1 identifier, 2 erase armed, 3 erase verify, 4 program armed, 5 program verify) |
| arr_addr | output | 17 | Address presented to the array |
| prog_addr | output | 17 | Latched program target address |
| prog_data | output | 8 | Latched program data |
| prog_start | output | 1 | One-cycle program start strobe |
| erase_start | output | 1 | One-cycle erase start strobe |

## Verification
A table of command bytes is applied in a running sequence. Each command is followed by a read at a different address, so the check can tell whether the data came from the live address, from an address latched earlier, or from the identifier bytes. Both encodings of each read command are used, and unknown bytes are written from read and identifier modes, so a decoder that handles only one encoding, or that keeps its mode on a bad byte, gives the wrong byte back. Directed sequences then try the two-write program and erase paths with good and bad confirming bytes and with the voltage input low. They also write with chip-enable high, move the address between the two write-enable edges, and raise the identifier force in read mode. These cases show apart a strobe that fires when it should not, an address taken on the wrong edge, and an inhibit that changes the mode instead of ignoring the command.

// File: rtl/flashcmd_pkg.sv
`timescale 1ns/1ps
package flashcmd_pkg;

  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    MD_READ      = 3'd0,
    MD_IDENT     = 3'd1,
    MD_ERASE_ARM = 3'd2,
    MD_ERASE_CHK = 3'd3,
    MD_PROG_ARM  = 3'd4,
    MD_PROG_CHK  = 3'd5
  } mode_e;

  typedef enum logic [2:0] {
    OP_READ, OP_IDENT, OP_ERASE, OP_ECHK, OP_PROG, OP_PCHK, OP_BAD
  } op_e;

  // Map a command byte to an operation class.
  function automatic op_e classify(input logic [BYTE_W-1:0] b);
    case (b)
      8'h00, 8'hFF: return OP_READ;
      8'h90, 8'h80: return OP_IDENT;
      8'h20:        return OP_ERASE;
      8'hA0:        return OP_ECHK;
      8'h40:        return OP_PROG;
      8'hC0:        return OP_PCHK;
      default:      return OP_BAD;
    endcase
  endfunction

  // Operations that touch the array (or prepare to) need programming voltage.
  function automatic logic needs_vpp(input op_e o);
    return (o == OP_ERASE) || (o == OP_ECHK) || (o == OP_PROG) || (o == OP_PCHK);
  endfunction

  function automatic mode_e mode_of(input op_e o);
    case (o)
      OP_IDENT: return MD_IDENT;
      OP_ERASE: return MD_ERASE_ARM;
      OP_ECHK:  return MD_ERASE_CHK;
      OP_PROG:  return MD_PROG_ARM;
      OP_PCHK:  return MD_PROG_CHK;
      default:  return MD_READ;
    endcase
  endfunction

  function automatic logic [BYTE_W-1:0] id_byte(input logic sel_dev,
                                                input logic [BYTE_W-1:0] mfr,
                                                input logic [BYTE_W-1:0] dev);
    return sel_dev ? dev : mfr;
  endfunction

endpackage

// File: rtl/flashcmd_edge.sv
`timescale 1ns/1ps
module flashcmd_edge #(
  parameter int ADDR_W = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  output logic              wr_fall,
  output logic              wr_rise,
  output logic [ADDR_W-1:0] lat_addr
);
  logic we_q;

  assign wr_fall = we_q & ~we_n & ~ce_n;
  assign wr_rise = ~we_q & we_n & ~ce_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_q     <= 1'b1;
      lat_addr <= '0;
    end else begin
      we_q <= we_n;
      if (wr_fall) lat_addr <= addr;
    end
  end
endmodule

// File: rtl/flashcmd_decode.sv
`timescale 1ns/1ps
module flashcmd_decode
  import flashcmd_pkg::*;
#(
  parameter int ADDR_W = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_rise,
  input  logic [BYTE_W-1:0] wr_byte,
  input  logic [ADDR_W-1:0] lat_addr,
  input  logic              vpp_ok,
  output mode_e             mode,
  output logic [ADDR_W-1:0] prog_addr,
  output logic [BYTE_W-1:0] prog_data,
  output logic [ADDR_W-1:0] ver_addr,
  output logic              prog_start,
  output logic              erase_start
);
  op_e   op;
  mode_e mode_d;
  logic  do_prog, do_erase, do_vlatch;

  assign op = classify(wr_byte);

  always_comb begin
    mode_d    = mode;
    do_prog   = 1'b0;
    do_erase  = 1'b0;
    do_vlatch = 1'b0;
    if (wr_rise) begin
      case (mode)
        MD_PROG_ARM: begin
          do_prog = vpp_ok;
          mode_d  = MD_READ;
        end
        MD_ERASE_ARM: begin
          do_erase = vpp_ok && (op == OP_ERASE);
          mode_d   = MD_READ;
        end
        default: begin
          if (!(needs_vpp(op) && !vpp_ok)) begin
            mode_d    = mode_of(op);
            do_vlatch = (op == OP_ECHK);
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode        <= MD_READ;
      prog_addr   <= '0;
      prog_data   <= '0;
      ver_addr    <= '0;
      prog_start  <= 1'b0;
      erase_start <= 1'b0;
    end else begin
      mode        <= mode_d;
      prog_start  <= do_prog;
      erase_start <= do_erase;
      if (do_prog) begin
        prog_addr <= lat_addr;
        prog_data <= wr_byte;
      end
      if (do_vlatch) ver_addr <= lat_addr;
    end
  end
endmodule

// File: rtl/flashcmd_rdmux.sv
`timescale 1ns/1ps
module flashcmd_rdmux
  import flashcmd_pkg::*;
#(
  parameter int              ADDR_W   = 17,
  parameter logic [BYTE_W-1:0] MFR_CODE = 8'h89,
  parameter logic [BYTE_W-1:0] DEV_CODE = 8'hB4
) (
  input  mode_e             mode,
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] ver_addr,
  input  logic [ADDR_W-1:0] prog_addr,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic              id_force,
  input  logic [BYTE_W-1:0] arr_rdata,
  output logic [ADDR_W-1:0] arr_addr,
  output logic [BYTE_W-1:0] dq_out,
  output logic              dq_oe
);
  logic use_id;

  always_comb begin
    case (mode)
      MD_ERASE_CHK: arr_addr = ver_addr;
      MD_PROG_CHK:  arr_addr = prog_addr;
      default:      arr_addr = addr;
    endcase
  end

  assign use_id = id_force || (mode == MD_IDENT);
  assign dq_oe  = ~ce_n & ~oe_n & we_n;
  assign dq_out = !dq_oe ? '0 :
                  use_id ? id_byte(addr[0], MFR_CODE, DEV_CODE) : arr_rdata;
endmodule

// File: rtl/flashcmd_if.sv
`timescale 1ns/1ps
module flashcmd_if
  import flashcmd_pkg::*;
#(
  parameter int          ADDR_W   = 17,
  parameter logic [7:0]  MFR_CODE = 8'h89,
  parameter logic [7:0]  DEV_CODE = 8'hB4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        din,
  input  logic              vpp_ok,
  input  logic              id_force,
  input  logic [7:0]        arr_rdata,
  output logic [7:0]        dq_out,
  output logic              dq_oe,
  output logic [2:0]        mode,
  output logic [ADDR_W-1:0] arr_addr,
  output logic [ADDR_W-1:0] prog_addr,
  output logic [7:0]        prog_data,
  output logic              prog_start,
  output logic              erase_start
);
  logic              we_fall;
  logic              we_rise;
  logic [ADDR_W-1:0] lat_addr;
  logic [ADDR_W-1:0] ver_addr;
  mode_e             mode_q;

  flashcmd_edge #(.ADDR_W(ADDR_W)) u_edge (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .addr(addr),
    .wr_fall(we_fall), .wr_rise(we_rise), .lat_addr(lat_addr)
  );

  flashcmd_decode #(.ADDR_W(ADDR_W)) u_dec (
    .clk(clk), .rst_n(rst_n), .wr_rise(we_rise), .wr_byte(din),
    .lat_addr(lat_addr), .vpp_ok(vpp_ok), .mode(mode_q),
    .prog_addr(prog_addr), .prog_data(prog_data), .ver_addr(ver_addr),
    .prog_start(prog_start), .erase_start(erase_start)
  );

  flashcmd_rdmux #(.ADDR_W(ADDR_W), .MFR_CODE(MFR_CODE), .DEV_CODE(DEV_CODE)) u_mux (
    .mode(mode_q), .addr(addr), .ver_addr(ver_addr), .prog_addr(prog_addr),
    .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n), .id_force(id_force),
    .arr_rdata(arr_rdata), .arr_addr(arr_addr), .dq_out(dq_out), .dq_oe(dq_oe)
  );

  assign mode = mode_q;
endmodule

// File: rtl/flashcmd_if_chk.sv
`timescale 1ns/1ps
module flashcmd_if_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ce_n,
  input logic       we_n,
  input logic       vpp_ok,
  input logic       we_rise,
  input logic [2:0] mode,
  input logic       prog_start,
  input logic       erase_start,
  input logic       dq_oe
);
  p_mode_legal_r1: assert property (@(posedge clk) disable iff (!rst_n)
    mode <= 3'd5);

  p_ce_ignore_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ce_n |=> $stable(mode));

  p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !we_rise |=> $stable(mode));

  p_erase_once_r5: assert property (@(posedge clk) disable iff (!rst_n)
    erase_start |=> !erase_start);

  p_prog_once_r6: assert property (@(posedge clk) disable iff (!rst_n)
    prog_start |=> !prog_start);

  p_strobe_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(prog_start && erase_start));

  p_no_strobe_lowv_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !vpp_ok |=> (!prog_start && !erase_start));

  p_strobe_after_arm_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_start || erase_start) |-> mode == 3'd0);

  p_no_drive_in_write_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> !dq_oe);
endmodule

bind flashcmd_if flashcmd_if_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .vpp_ok(vpp_ok),
  .we_rise(we_rise), .mode(mode), .prog_start(prog_start),
  .erase_start(erase_start), .dq_oe(dq_oe)
);

// File: tb/flashcmd_if_test.sv
`timescale 1ns/1ps
module flashcmd_if_test;
  localparam int AW = 17;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [7:0]    din = '0;
  logic          vpp_ok = 1'b1, id_force = 1'b0;
  logic [7:0]    arr_rdata;
  logic [7:0]    dq_out;
  logic          dq_oe;
  logic [2:0]    mode;
  logic [AW-1:0] arr_addr, prog_addr;
  logic [7:0]    prog_data;
  logic          prog_start, erase_start;

  int  n_chk = 0, n_bad = 0;
  bit  done = 0;
  logic saw_prog, saw_erase, post_prog, post_erase;

  always #2 clk = ~clk;

  // Behavioural array contents: a fixed function of the address.
  function automatic logic [7:0] ref_arr(input logic [AW-1:0] a);
    return a[7:0] ^ a[16:9] ^ 8'h3C;
  endfunction

  assign arr_rdata = ref_arr(arr_addr);

  flashcmd_if uut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .addr(addr), .din(din), .vpp_ok(vpp_ok), .id_force(id_force),
    .arr_rdata(arr_rdata), .dq_out(dq_out), .dq_oe(dq_oe), .mode(mode),
    .arr_addr(arr_addr), .prog_addr(prog_addr), .prog_data(prog_data),
    .prog_start(prog_start), .erase_start(erase_start)
  );

  task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", what, act, exp);
    end
  endtask

  task automatic bus_write(input logic [AW-1:0] a_fall, input logic [AW-1:0] a_rise,
                           input logic [7:0] d, input logic ce_on);
    @(negedge clk); ce_n = !ce_on; oe_n = 1'b1; addr = a_fall; din = d;
    @(negedge clk); we_n = 1'b0;
    @(negedge clk); we_n = 1'b1; addr = a_rise;
    @(negedge clk); saw_prog = prog_start; saw_erase = erase_start;
    @(negedge clk); post_prog = prog_start; post_erase = erase_start; ce_n = 1'b1;
  endtask

  task automatic wr(input logic [7:0] d);
    bus_write('0, '0, d, 1'b1);
  endtask

  task automatic bus_read(input logic [AW-1:0] a, output logic [7:0] d, output logic oe);
    @(negedge clk); ce_n = 1'b0; oe_n = 1'b0; addr = a;
    #1; d = dq_out; oe = dq_oe;
    oe_n = 1'b1; ce_n = 1'b1;
  endtask

  typedef struct packed {
    logic [7:0]    cmd;
    logic [AW-1:0] wa;
    logic [AW-1:0] ra;
    logic [2:0]    md;
    logic [1:0]    src;   // 0 live address, 1 write address, 2 identifier
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{8'h90, 17'h00000, 17'h00000, 3'd1, 2'd2},
    '{8'h80, 17'h00000, 17'h00003, 3'd1, 2'd2},
    '{8'hFF, 17'h00000, 17'h01234, 3'd0, 2'd0},
    '{8'hA0, 17'h00ABC, 17'h11111, 3'd3, 2'd1},
    '{8'h00, 17'h00000, 17'h00FF0, 3'd0, 2'd0},
    '{8'h20, 17'h00000, 17'h00222, 3'd2, 2'd0},
    '{8'h33, 17'h00000, 17'h00444, 3'd0, 2'd0},
    '{8'h5A, 17'h00000, 17'h10000, 3'd0, 2'd0},
    '{8'h90, 17'h00000, 17'h00002, 3'd1, 2'd2},
    '{8'h7E, 17'h00000, 17'h00002, 3'd0, 2'd0}
  };

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got hung expected done");
      summary();
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    logic       oe;
    logic [7:0] exp_d;

    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 mode after reset", mode, 0);
    check("R1 prog_start after reset", prog_start, 0);
    check("R1 erase_start after reset", erase_start, 0);
    rst_n = 1'b1;
    bus_read(17'h0ABCD, d, oe);
    check("R1 read array after reset", d, ref_arr(17'h0ABCD));
    check("R12 dq_oe during read", oe, 1);

    // Vector table: command, then read
    for (int i = 0; i < NV; i++) begin
      bus_write(VECS[i].wa, VECS[i].wa, VECS[i].cmd, 1'b1);
      check($sformatf("vector %0d mode (R3 R4 R5 R7 R11)", i), mode, VECS[i].md);
      bus_read(VECS[i].ra, d, oe);
      case (VECS[i].src)
        2'd0:    exp_d = ref_arr(VECS[i].ra);
        2'd1:    exp_d = ref_arr(VECS[i].wa);
        default: exp_d = VECS[i].ra[0] ? 8'hB4 : 8'h89;
      endcase
      check($sformatf("vector %0d read data (R3 R4 R7 R11)", i), d, exp_d);
    end

    // R6: program sequence
    wr(8'h40);
    check("R6 mode program armed", mode, 4);
    bus_write(17'h1ABCD, 17'h1ABCD, 8'h6E, 1'b1);
    check("R6 prog_start pulse", saw_prog, 1);
    check("R6 prog_start one cycle", post_prog, 0);
    check("R6 prog_addr", prog_addr, 17'h1ABCD);
    check("R6 prog_data", prog_data, 8'h6E);
    check("R6 mode back to read", mode, 0);
    check("R6 no erase strobe", saw_erase, 0);

    // R8: program verify
    wr(8'hC0);
    check("R8 mode program verify", mode, 5);
    check("R8 arr_addr follows prog_addr", arr_addr, 17'h1ABCD);
    bus_read(17'h00000, d, oe);
    check("R8 verify read data", d, ref_arr(17'h1ABCD));

    // R5: erase confirmed
    wr(8'h20);
    bus_write('0, '0, 8'h20, 1'b1);
    check("R5 erase_start pulse", saw_erase, 1);
    check("R5 erase_start one cycle", post_erase, 0);
    check("R5 mode after erase", mode, 0);

    // R5: erase aborted by other byte
    wr(8'h20);
    bus_write('0, '0, 8'h21, 1'b1);
    check("R5 no strobe on bad confirm", saw_erase, 0);

    // R9: low programming voltage
    wr(8'h90);
    vpp_ok = 1'b0;
    wr(8'h40); check("R9 40H ignored", mode, 1);
    wr(8'h20); check("R9 20H ignored", mode, 1);
    wr(8'hA0); check("R9 A0H ignored", mode, 1);
    wr(8'hC0); check("R9 C0H ignored", mode, 1);
    bus_read(17'h00000, d, oe);
    check("R9 still identifier after ignored cmds", d, 8'h89);
    vpp_ok = 1'b1;
    wr(8'h40);
    vpp_ok = 1'b0;
    bus_write(17'h00777, 17'h00777, 8'h11, 1'b1);
    check("R9 no prog strobe with low voltage", saw_prog, 0);
    check("R9 prog_addr kept", prog_addr, 17'h1ABCD);
    check("R9 mode back to read", mode, 0);
    vpp_ok = 1'b1;

    // R2: chip-enable high write ignored
    bus_write('0, '0, 8'h90, 1'b0);
    check("R2 write with ce high ignored", mode, 0);

    // R2: address taken at falling edge
    bus_write(17'h00123, 17'h00456, 8'hA0, 1'b1);
    bus_read(17'h00000, d, oe);
    check("R2 address from falling edge", d, ref_arr(17'h00123));

    // R3: FFH twice from identifier
    wr(8'h90);
    wr(8'hFF);
    wr(8'hFF);
    check("R3 double FFH returns to read", mode, 0);

    // R10: identifier force in read mode
    id_force = 1'b1;
    bus_read(17'h00001, d, oe);
    check("R10 forced device code", d, 8'hB4);
    bus_read(17'h00000, d, oe);
    check("R10 forced maker code", d, 8'h89);
    id_force = 1'b0;

    // R12: output enable gating
    @(negedge clk); ce_n = 1'b0; oe_n = 1'b1; #1;
    check("R12 no drive with oe high", dq_oe, 0);
    oe_n = 1'b0; we_n = 1'b0; #1;
    check("R12 no drive with we low", dq_oe, 0);
    we_n = 1'b1; ce_n = 1'b1; oe_n = 1'b1;

    done = 1;
    summary();
    $finish;
  end
endmodule